// File: doc/BRIEF.md
# Variable-Width CRC-32 Accumulator

This block keeps a running CRC-32 over a stream that arrives up to eight bytes per clock. Each cycle a 3-bit width code says how many bytes at the top of a 64-bit bus belong to the stream. When the qualifier is high, the block folds those bytes into its 32-bit register, highest byte first. The same engine serves a transmit path, which appends the check value, and a receive path, where logic outside the block compares the register against the expected residue.

The register is shown on the output exactly as it is held. A consumer must complement it to get the check value. A synchronous initialise input reloads the preset value and can be combined with data in the same cycle. A power-down input freezes the engine, and an active-low synchronous reset returns it to the preset.

Top module: `vcrc32_engine`

## Requirements
- R1: The update uses the generator polynomial 0x04C11DB7, non-reflected. Each byte is XORed into register bits [31:24] and then shifted left eight times, with the polynomial XORed in whenever the bit shifted out is 1. Bytes are taken from the most significant end downward.
- R2: Width code n (0 to 7) selects n+1 bytes, `data_in[63 -: 8*(n+1)]`. Code 000 selects bits [63:56] and code 111 selects all of [63:0].
- R3: Bytes below the selected width have no effect on the result.
- R4: Data enters the register only in cycles where `data_vld` is 1. With `data_vld`, `crc_init` and `pwr_dn` all 0, the register holds.
- R5: When `crc_init` is 1, the register is loaded with `INIT_VAL` (default 0xFFFFFFFF). If `data_vld` is also 1, that cycle's bytes are folded into `INIT_VAL` instead of into the old register value.
- R6: `crc_out` is the raw register. For the ASCII string "123456789" processed after initialisation, it reads 0x0376E6E7, whose complement 0xFC891918 is the check value.
- R7: When `rst_n` is 0 at a clock edge, the register becomes `INIT_VAL`, whatever the other inputs are.
- R8: While `pwr_dn` is 1 (and `rst_n` is 1), the register holds and ignores both `data_vld` and `crc_init`. Once `pwr_dn` returns to 0, accumulation continues from the held value.
- R9: The result of a cycle's inputs appears on `crc_out` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Synchronous active-low reset to the preset |
| pwr_dn | input | 1 | Freeze the engine while high |
| crc_init | input | 1 | Reload the preset this cycle |
| data_vld | input | 1 | Absorb the selected bytes this cycle |
| width_code | input | 3 | Number of valid bytes minus one |
| data_in | input | 64 | Data, valid bytes packed at the top |
| crc_out | output | 32 | Raw CRC register, to be complemented by the user |

## Verification
On every cycle the assertions check the control behaviour: the preset after reset, holding while idle, freezing while powered down, the preset after an initialise with no data, and a known output. The arithmetic can only be shown by the bench's scenarios. That covers the polynomial and byte order, each width code, the low bytes being ignored, the check string, and an initialise combined with data. In each of these the bench compares `crc_out` with a bit-serial model of the requirements.

// File: rtl/vcrc32_pkg.sv
// Package: vcrc32_pkg
// Shared constants for the variable-width CRC-32 accumulator.
// Assumes bytes are 8 bits and the bus carries a whole number of bytes.
package vcrc32_pkg;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned CRC_W        = 32;
    localparam logic [31:0] POLY_CRC32   = 32'h04C1_1DB7;
    localparam logic [31:0] PRESET_CRC32 = 32'hFFFF_FFFF;
endpackage

// File: rtl/vcrc32_lane_mask.sv
// Module: vcrc32_lane_mask
// Turns the width code into a per-byte enable vector. Lane i covers
// data bits [8i+7:8i]. The top lane is always enabled and lower lanes
// are enabled downward as the code grows.
// Assumes LANES is a power of two and CODE_W = log2(LANES).
module vcrc32_lane_mask #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned CODE_W = $clog2(LANES)
) (
    input  logic [CODE_W-1:0] width_code,
    output logic [LANES-1:0]  lane_en
);
    // Decode: lane i is enabled when its distance from the top is <= code.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned DIST = LANES - 1 - i;
        assign lane_en[i] = (DIST[CODE_W-1:0] <= width_code);
    end
endmodule

// File: rtl/vcrc32_byte_step.sv
// Module: vcrc32_byte_step
// Combinational update of a CRC register by one byte, MSB first and
// non-reflected. The byte is XORed into the top of the register and then
// shifted through BYTE_W single-bit steps.
// Assumes CRC_W >= BYTE_W.
module vcrc32_byte_step #(
    parameter int unsigned         CRC_W  = 32,
    parameter int unsigned         BYTE_W = 8,
    parameter logic [CRC_W-1:0]    POLY   = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);
    localparam int unsigned LOW_W = CRC_W - BYTE_W;

    logic [CRC_W-1:0] bit_chain [BYTE_W+1];

    // Seed: merge the byte into the top of the register.
    assign bit_chain[0] = crc_in ^ {byte_in, {LOW_W{1'b0}}};

    // Shift chain: one LFSR step per bit.
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign bit_chain[b+1] = bit_chain[b][CRC_W-1]
                              ? ({bit_chain[b][CRC_W-2:0], 1'b0} ^ POLY)
                              :  {bit_chain[b][CRC_W-2:0], 1'b0};
    end

    assign crc_out = bit_chain[BYTE_W];
endmodule

// File: rtl/vcrc32_fold.sv
// Module: vcrc32_fold
// Folds the enabled byte lanes of a wide word into a CRC seed, starting
// at the top lane and moving down. A disabled lane passes the running
// value through unchanged.
// Assumes the enabled lanes are contiguous from the top, as the lane
// mask produces them.
module vcrc32_fold #(
    parameter int unsigned      LANES  = 8,
    parameter int unsigned      BYTE_W = 8,
    parameter int unsigned      CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
    parameter int unsigned      DATA_W = LANES * BYTE_W
) (
    input  logic [CRC_W-1:0]  seed,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  lane_en,
    output logic [CRC_W-1:0]  folded
);
    logic [CRC_W-1:0] stage [LANES+1];

    assign stage[0] = seed;

    // Lane chain: stage k handles lane LANES-1-k, the most significant first.
    for (genvar k = 0; k < LANES; k++) begin : g_stage
        localparam int unsigned LANE = LANES - 1 - k;
        logic [CRC_W-1:0] stepped;

        vcrc32_byte_step #(
            .CRC_W  (CRC_W),
            .BYTE_W (BYTE_W),
            .POLY   (POLY)
        ) u_step (
            .crc_in  (stage[k]),
            .byte_in (data[LANE*BYTE_W +: BYTE_W]),
            .crc_out (stepped)
        );

        assign stage[k+1] = lane_en[LANE] ? stepped : stage[k];
    end

    assign folded = stage[LANES];
endmodule

// File: rtl/vcrc32_engine.sv
// Module: vcrc32_engine
// Variable-width CRC-32 accumulator. Per cycle it absorbs 1..LANES bytes
// packed at the top of data_in, as chosen by width_code and qualified by
// data_vld. crc_out is the raw register; the user complements it.
// Priority: reset, then power-down (freeze), then initialise (reseed),
// then data. Assumes one clock domain and a synchronous active-low reset.
module vcrc32_engine #(
    parameter int unsigned   DATA_W   = 64,
    parameter logic [31:0]   POLY     = vcrc32_pkg::POLY_CRC32,
    parameter logic [31:0]   INIT_VAL = vcrc32_pkg::PRESET_CRC32,
    parameter int unsigned   LANES    = DATA_W / vcrc32_pkg::BYTE_W,
    parameter int unsigned   CODE_W   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              crc_init,
    input  logic              data_vld,
    input  logic [CODE_W-1:0] width_code,
    input  logic [DATA_W-1:0] data_in,
    output logic [31:0]       crc_out
);
    import vcrc32_pkg::*;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] folded;
    logic [CRC_W-1:0] crc_d;
    logic [LANES-1:0] lane_en;
    logic             load_en;

    vcrc32_lane_mask #(
        .LANES  (LANES),
        .CODE_W (CODE_W)
    ) u_mask (
        .width_code (width_code),
        .lane_en    (lane_en)
    );

    // Seed select: initialise restarts from the preset this cycle.
    always_comb seed = crc_init ? INIT_VAL : crc_q;

    vcrc32_fold #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY),
        .DATA_W (DATA_W)
    ) u_fold (
        .seed    (seed),
        .data    (data_in),
        .lane_en (lane_en),
        .folded  (folded)
    );

    // Next value: fold the data only when it is qualified.
    always_comb crc_d = data_vld ? folded : seed;

    // Load enable: any request while the engine is powered.
    always_comb load_en = ~pwr_dn & (crc_init | data_vld);

    // CRC register: reset wins, otherwise load on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= INIT_VAL;
        else if (load_en)
            crc_q <= crc_d;
    end

    assign crc_out = crc_q;
endmodule

// File: rtl/vcrc32_engine_chk.sv
// Module: vcrc32_engine_chk
// Cycle-by-cycle property checks on the control behaviour of
// vcrc32_engine, attached by bind. Observes ports only.
module vcrc32_engine_chk #(
    parameter logic [31:0] INIT_VAL = 32'hFFFF_FFFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_dn,
    input logic        crc_init,
    input logic        data_vld,
    input logic [31:0] crc_out
);
    logic seen_edge;

    // Track the first clock edge so $past never looks before time zero.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R7: a reset edge leaves the preset in the register.
    p_reset_preset_r7: assert property (@(posedge clk)
        disable iff (!rst_n)
        (seen_edge && $past(!rst_n)) |-> (crc_out == INIT_VAL));

    // R8: power-down freezes the register.
    p_pd_freeze_r8: assert property (@(posedge clk)
        disable iff (!rst_n)
        (seen_edge && $past(rst_n && pwr_dn)) |-> (crc_out == $past(crc_out)));

    // R4: no request means no change.
    p_idle_hold_r4: assert property (@(posedge clk)
        disable iff (!rst_n)
        (seen_edge && $past(rst_n && !pwr_dn && !crc_init && !data_vld))
        |-> (crc_out == $past(crc_out)));

    // R5: an initialise with no data leaves exactly the preset.
    p_init_preset_r5: assert property (@(posedge clk)
        disable iff (!rst_n)
        (seen_edge && $past(rst_n && !pwr_dn && crc_init && !data_vld))
        |-> (crc_out == INIT_VAL));

    // R6: once reset has been applied the raw register is always known.
    p_known_out_r6: assert property (@(posedge clk)
        disable iff (!rst_n)
        seen_edge |-> !$isunknown(crc_out));
endmodule

bind vcrc32_engine vcrc32_engine_chk #(.INIT_VAL(INIT_VAL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .crc_init (crc_init),
    .data_vld (data_vld),
    .crc_out  (crc_out)
);

// File: tb/tb_vcrc32_engine.sv
module tb_vcrc32_engine;
    localparam logic [31:0] POLY = 32'h04C1_1DB7;
    localparam logic [31:0] INIT = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        crc_init = 1'b0;
    logic        data_vld = 1'b0;
    logic [2:0]  width_code = 3'd0;
    logic [63:0] data_in = 64'd0;
    logic [31:0] crc_out;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    logic [31:0] model = INIT;
    logic [31:0] snap;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    vcrc32_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .crc_init   (crc_init),
        .data_vld   (data_vld),
        .width_code (width_code),
        .data_in    (data_in),
        .crc_out    (crc_out)
    );

    // Vector fields: {init, vld, code[2:0], data[63:0]}
    localparam int NV = 10;
    localparam logic [68:0] VEC [NV] = '{
        {1'b1, 1'b1, 3'd7, 64'h0123_4567_89AB_CDEF},
        {1'b0, 1'b1, 3'd0, 64'hA5FF_FFFF_FFFF_FFFF},
        {1'b0, 1'b1, 3'd1, 64'h3C7E_0000_0000_0000},
        {1'b0, 1'b1, 3'd2, 64'h0000_0112_3456_789A},
        {1'b0, 1'b1, 3'd3, 64'hDEAD_BEEF_1111_2222},
        {1'b0, 1'b0, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 1'b1, 3'd4, 64'h8000_0000_01C0_FFEE},
        {1'b0, 1'b1, 3'd5, 64'h1357_9BDF_0246_AAAA},
        {1'b1, 1'b0, 3'd6, 64'h5555_5555_5555_5555},
        {1'b0, 1'b1, 3'd6, 64'hCAFE_F00D_1234_5600}
    };

    // Bit-serial reference: MSB-first bytes, top of the bus first.
    function automatic logic [31:0] ref_fold(logic [31:0] c, logic [63:0] d, logic [2:0] code);
        for (int b = 0; b <= int'(code); b++) begin
            c = c ^ {d[63-8*b -: 8], 24'd0};
            for (int s = 0; s < 8; s++)
                c = c[31] ? ((c << 1) ^ POLY) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(string req, logic [31:0] exp);
        n_run++;
        if (crc_out !== exp) begin
            n_fail++;
            $display("FAIL %s: crc_out=%08h expected=%08h", req, crc_out, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample at the next falling edge.
    task automatic cyc(logic i, logic v, logic [2:0] c, logic [63:0] d);
        crc_init = i; data_vld = v; width_code = c; data_in = d;
        @(negedge clk);
        crc_init = 1'b0; data_vld = 1'b0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R7 reset preset", INIT);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1, R2, R4, R5, R9
        for (int k = 0; k < NV; k++) begin
            logic [31:0] seed;
            seed = VEC[k][68] ? INIT : model;
            model = VEC[k][67] ? ref_fold(seed, VEC[k][63:0], VEC[k][66:64]) : seed;
            cyc(VEC[k][68], VEC[k][67], VEC[k][66:64], VEC[k][63:0]);
            check($sformatf("R1/R2 table vector %0d", k), model);
        end

        // R6: check string "123456789"
        cyc(1'b1, 1'b1, 3'd7, 64'h3132_3334_3536_3738);
        cyc(1'b0, 1'b1, 3'd0, 64'h39AA_BBCC_DDEE_FF00);
        check("R6 raw check string", 32'h0376_E6E7);
        check("R6 complemented check", ~32'hFC89_1918);
        model = 32'h0376_E6E7;

        // R3: low bytes outside the width do not matter
        cyc(1'b1, 1'b1, 3'd2, 64'h1122_3300_0000_0000);
        snap = crc_out;
        cyc(1'b1, 1'b1, 3'd2, 64'h1122_33FF_EE99_7766);
        check("R3 low bytes ignored", snap);
        check("R3 value", ref_fold(INIT, 64'h1122_3300_0000_0000, 3'd2));
        model = snap;

        // R4: idle cycles hold
        cyc(1'b0, 1'b0, 3'd7, 64'hFFFF_0000_FFFF_0000);
        cyc(1'b0, 1'b0, 3'd0, 64'h1234_0000_0000_0000);
        check("R4 hold without valid", model);

        // R8: power-down ignores data and initialise, then resumes
        pwr_dn = 1'b1;
        cyc(1'b0, 1'b1, 3'd7, 64'hABCD_EF01_2345_6789);
        check("R8 valid ignored while down", model);
        cyc(1'b1, 1'b0, 3'd0, 64'd0);
        check("R8 init ignored while down", model);
        pwr_dn = 1'b0;
        model = ref_fold(model, 64'h7700_0000_0000_0000, 3'd0);
        cyc(1'b0, 1'b1, 3'd0, 64'h7700_0000_0000_0000);
        check("R8 resume from held state", model);

        // R5: init together with data restarts then folds
        model = ref_fold(INIT, 64'hFEDC_BA98_7654_3210, 3'd3);
        cyc(1'b1, 1'b1, 3'd3, 64'hFEDC_BA98_7654_3210);
        check("R5 init with data", model);

        // R9: result appears after exactly one edge
        crc_init = 1'b1; data_vld = 1'b1; width_code = 3'd0; data_in = 64'h4200_0000_0000_0000;
        @(posedge clk); #1;
        check("R9 one-edge latency", ref_fold(INIT, 64'h4200_0000_0000_0000, 3'd0));
        @(negedge clk);
        crc_init = 1'b0; data_vld = 1'b0;

        // R7: reset beats init, valid and power-down
        rst_n = 1'b0; pwr_dn = 1'b1;
        cyc(1'b1, 1'b1, 3'd7, 64'h0F0F_0F0F_0F0F_0F0F);
        check("R7 reset priority", INIT);
        rst_n = 1'b1; pwr_dn = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule